// File: doc/BRIEF.md
# Keyed Flash Row Program Controller

This block sits between a processor's register bus and an on-chip program flash and runs a whole-row erase or a whole-row program. Software sets up a control word, picks a row with a page register and an in-page offset register, fills a bank of row write latches, and then unlocks the controller by writing two key values to a key register. Only then does setting the start bit launch the operation. While the operation runs, a stall output holds the processor and the start bit reads back as a busy flag. Hardware clears that bit when the operation ends.

A row holds `ROW_WORDS` words of `WORD_W` bits. The flash word address is the page register joined to bits [OFF_W-1:1] of the offset register, so each word spans two offset units. The controller replaces the low index bits with its own word counter. During the first `ROW_WORDS` cycles of an operation it writes one word per cycle to the array. The rest of the `OP_CYCLES` window is a hold that stands in for the array's erase or program time. A start that is not allowed sets a sticky error flag and writes nothing.

Key unlock FSM states: `K_LOCKED`, `K_HALF` (first key seen), `K_OPEN`. Transitions: LOCKED→HALF on key 0x55; HALF→OPEN on key 0xAA. Every other key write, and every control write from any state, returns it to LOCKED. Sequencer states: `M_IDLE`, `M_ROW` (one flash word per cycle), `M_HOLD` (timing wait). Transitions: IDLE→ROW on an accepted start; ROW→HOLD after the last word; HOLD→IDLE when the count reaches `OP_CYCLES-1`. ROW→IDLE is used directly only when `OP_CYCLES` equals `ROW_WORDS`.

Top module: `flash_row_ctrl`

## Requirements
- R1: After reset, `ctrl_q` is 0, `stall` and `fl_we` are 0, and every row write latch holds all ones.
- R2: The unlock opens only when a key write of 0x55 (bits [7:0] of `bus_wdata`, `bus_sel`=3) is directly followed by a key write of 0xAA. Any other key value, or 0x55 twice, returns the unlock to locked.
- R3: Any control-register write (`bus_sel`=0) uses up the unlock, whether or not that write starts an operation.
- R4: A control write with bit 15 set starts an operation only when all three of these hold: the unlock is open, the write-enable bit 14 was already 1 in the stored control word, and bits [3:0] of the written value equal 4'h1, the program-flash row target. If any of them fails, error bit 13 is set, the operation does not start, and the array gets no write.
- R5: Error bit 13 stays set until a control write with bit 13 at 0 is accepted. Key, page, offset and latch writes leave it unchanged.
- R6: An accepted start raises `stall` for exactly `OP_CYCLES` cycles, starting in the cycle after the start write. `ctrl_q[15]` reads 1 for the same cycles.
- R7: Bit 6 of the start write selects erase (1) or program (0). An erase writes all ones to every word of the row whose address is {page, offset[OFF_W-1:IDX_W+1]}.
- R8: A program writes write-latch word i to word i of the row. After the program completes, all latches return to all ones.
- R9: While `stall` is high, every bus write is ignored. This covers control, key, page, offset and latch writes.
- R10: `fl_we` is high only during the first `ROW_WORDS` cycles of `stall`. The word index (low `IDX_W` bits of `fl_addr`) goes from 0 up by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_sel | input | 3 | Register select: 0 control, 1 page, 2 offset, 3 key, 4 write latch |
| bus_idx | input | IDX_W | Write-latch word index for latch writes |
| bus_wdata | input | WORD_W | Write data |
| ctrl_q | output | 16 | Control word: [15] busy, [14] write enable, [13] error, [6] erase select, [3:0] target |
| stall | output | 1 | Processor stall for the whole operation |
| fl_we | output | 1 | Flash array word write strobe |
| fl_addr | output | FA_W | Flash word address {row, word index} |
| fl_wdata | output | WORD_W | Flash word write data |

## Verification
The assertions assume three things about the block's inputs. `bus_sel` carries only the five defined codes. `bus_wdata` is fully known whenever `bus_we` is high. `OP_CYCLES` is at least `ROW_WORDS`, so the write burst always fits inside the stall window. The stimulus drives every input on the falling edge, uses only the defined register codes, and picks an operation length longer than a row. Writes issued during an operation land on separate cycles of the stall, so the ignore rule is tested against clean single writes rather than overlapping strobes.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;

    // register select codes on bus_sel
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_PAGE  = 3'd1;
    localparam logic [2:0] SEL_OFFS  = 3'd2;
    localparam logic [2:0] SEL_KEY   = 3'd3;
    localparam logic [2:0] SEL_LATCH = 3'd4;

    // unlock key values, in required order
    localparam logic [7:0] KEY_STEP1 = 8'h55;
    localparam logic [7:0] KEY_STEP2 = 8'hAA;

    // control word bit positions
    localparam int CB_GO    = 15;
    localparam int CB_WREN  = 14;
    localparam int CB_ERR   = 13;
    localparam int CB_ERASE = 6;

    localparam logic [3:0] TGT_PFLASH_ROW = 4'h1;

    typedef enum logic [1:0] {
        K_LOCKED = 2'd0,
        K_HALF   = 2'd1,
        K_OPEN   = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ROW  = 2'd1,
        M_HOLD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
    import flash_row_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_val,
    input  logic       ctrl_we,
    output logic       unlocked
);

    key_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= K_LOCKED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            state_d = K_LOCKED;
        end else if (key_we) begin
            unique case (state_q)
                K_LOCKED: state_d = (key_val == KEY_STEP1) ? K_HALF : K_LOCKED;
                K_HALF:   state_d = (key_val == KEY_STEP2) ? K_OPEN : K_LOCKED;
                K_OPEN:   state_d = K_LOCKED;
                default:  state_d = K_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unlocked = (state_q == K_OPEN);
    end

endmodule

// File: rtl/flash_row_latches.sv
module flash_row_latches #(
    parameter  int WORD_W    = 24,
    parameter  int ROW_WORDS = 32,
    localparam int IDX_W     = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clear_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [ROW_WORDS-1:0][WORD_W-1:0] words;

    for (genvar g = 0; g < ROW_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '1;
            else if (clear_all)
                slot_q <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                slot_q <= wr_data;
        end
        assign words[g] = slot_q;
    end

    always_comb begin
        rd_data = words[rd_idx];
    end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_row_pkg::*;
#(
    parameter  int OP_CYCLES = 100000,
    parameter  int ROW_WORDS = 32,
    parameter  int ROW_W     = 18,
    localparam int IDX_W     = $clog2(ROW_WORDS),
    localparam int CNT_W     = $clog2(OP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_erase,
    input  logic [ROW_W-1:0] start_row,
    output logic             busy,
    output logic             word_we,
    output logic [IDX_W-1:0] word_idx,
    output logic [ROW_W-1:0] row_q,
    output logic             erase_q,
    output logic             prog_done
);

    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(ROW_WORDS - 1);
    localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(OP_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register with operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
            erase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == M_IDLE) begin
                cnt_q <= '0;
                if (start) begin
                    row_q   <= start_row;
                    erase_q <= start_erase;
                end
            end else if (state_d == M_IDLE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE: if (start) state_d = M_ROW;
            M_ROW: begin
                if (cnt_q == OP_LAST)       state_d = M_IDLE;
                else if (cnt_q == ROW_LAST) state_d = M_HOLD;
            end
            M_HOLD: if (cnt_q == OP_LAST) state_d = M_IDLE;
            default: state_d = M_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != M_IDLE);
        word_we   = (state_q == M_ROW);
        word_idx  = cnt_q[IDX_W-1:0];
        prog_done = (state_q != M_IDLE) && (cnt_q == OP_LAST) && !erase_q;
    end

endmodule

// File: rtl/flash_ctrl_reg.sv
module flash_ctrl_reg
    import flash_row_pkg::*;
#(
    parameter  int WORD_W    = 24,
    parameter  int PAGE_W    = 8,
    parameter  int OFF_W     = 16,
    parameter  int ROW_WORDS = 32,
    localparam int IDX_W     = $clog2(ROW_WORDS),
    localparam int ROW_W     = PAGE_W + OFF_W - IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              key_open,
    input  logic              busy,
    output logic [15:0]       ctrl_word,
    output logic              ctrl_wr,
    output logic              start,
    output logic              start_erase,
    output logic [ROW_W-1:0]  start_row
);

    logic              wren_q, err_q, erase_q;
    logic [3:0]        tgt_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  offs_q;
    logic              go_req;

    always_comb begin
        ctrl_wr     = wr_en && (sel == SEL_CTRL);
        go_req      = ctrl_wr && wdata[CB_GO];
        start       = go_req && key_open && wren_q && (wdata[3:0] == TGT_PFLASH_ROW);
        start_erase = wdata[CB_ERASE];
        start_row   = {page_q, offs_q[OFF_W-1:IDX_W+1]};
        ctrl_word   = {busy, wren_q, err_q, 6'b0, erase_q, 2'b0, tgt_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wren_q  <= 1'b0;
            err_q   <= 1'b0;
            erase_q <= 1'b0;
            tgt_q   <= '0;
            page_q  <= '0;
            offs_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) begin
                wren_q  <= wdata[CB_WREN];
                erase_q <= wdata[CB_ERASE];
                tgt_q   <= wdata[3:0];
                err_q   <= (go_req && !start) ? 1'b1 : (err_q & wdata[CB_ERR]);
            end
            if (sel == SEL_PAGE) page_q <= wdata[PAGE_W-1:0];
            if (sel == SEL_OFFS) offs_q <= wdata[OFF_W-1:0];
        end
    end

endmodule

// File: rtl/flash_row_ctrl.sv
module flash_row_ctrl
    import flash_row_pkg::*;
#(
    parameter  int WORD_W    = 24,
    parameter  int PAGE_W    = 8,
    parameter  int OFF_W     = 16,
    parameter  int ROW_WORDS = 32,
    parameter  int OP_CYCLES = 100000,
    localparam int IDX_W     = $clog2(ROW_WORDS),
    localparam int ROW_W     = PAGE_W + OFF_W - IDX_W - 1,
    localparam int FA_W      = ROW_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_sel,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [15:0]       ctrl_q,
    output logic              stall,
    output logic              fl_we,
    output logic [FA_W-1:0]   fl_addr,
    output logic [WORD_W-1:0] fl_wdata
);

    logic              wr_ok;
    logic              key_open;
    logic              ctrl_wr;
    logic              start, start_erase;
    logic [ROW_W-1:0]  start_row, row_q;
    logic              busy, word_we, erase_q, prog_done;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] latch_word;

    // all register writes are dropped while an operation runs
    always_comb begin
        wr_ok = bus_we && !busy;
    end

    flash_ctrl_reg #(
        .WORD_W(WORD_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .ROW_WORDS(ROW_WORDS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .sel(bus_sel), .wdata(bus_wdata),
        .key_open(key_open), .busy(busy), .ctrl_word(ctrl_q), .ctrl_wr(ctrl_wr),
        .start(start), .start_erase(start_erase), .start_row(start_row)
    );

    flash_key_unlock u_key (
        .clk(clk), .rst_n(rst_n),
        .key_we(wr_ok && (bus_sel == SEL_KEY)),
        .key_val(bus_wdata[7:0]),
        .ctrl_we(ctrl_wr),
        .unlocked(key_open)
    );

    flash_row_latches #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok && (bus_sel == SEL_LATCH)),
        .wr_idx(bus_idx), .wr_data(bus_wdata),
        .clear_all(prog_done),
        .rd_idx(word_idx), .rd_data(latch_word)
    );

    flash_op_seq #(.OP_CYCLES(OP_CYCLES), .ROW_WORDS(ROW_WORDS), .ROW_W(ROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_erase(start_erase),
        .start_row(start_row), .busy(busy), .word_we(word_we), .word_idx(word_idx),
        .row_q(row_q), .erase_q(erase_q), .prog_done(prog_done)
    );

    always_comb begin
        stall    = busy;
        fl_we    = word_we;
        fl_addr  = {row_q, word_idx};
        fl_wdata = erase_q ? '1 : latch_word;
    end

endmodule

// File: rtl/flash_row_ctrl_chk.sv
module flash_row_ctrl_chk #(
    parameter int OP_CYCLES = 100000,
    parameter int FA_W      = 23,
    parameter int IDX_W     = 5,
    parameter int WORD_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [2:0]        bus_sel,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [15:0]       ctrl_q,
    input logic              stall,
    input logic              fl_we,
    input logic [FA_W-1:0]   fl_addr,
    input logic              key_open
);

    localparam int CW = $clog2(OP_CYCLES + 2);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= '0;
        else if (stall) run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    a_r6_stall_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_len == CW'(OP_CYCLES)));

    a_r10_write_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> stall);

    a_r10_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && $past(fl_we)) |-> (fl_addr[IDX_W-1:0] == IDX_W'($past(fl_addr[IDX_W-1:0]) + 1'b1)));

    a_r7_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |-> (fl_addr[FA_W-1:IDX_W] == $past(fl_addr[FA_W-1:IDX_W])));

    a_r4_locked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == 3'd0 && bus_wdata[15] && !stall && !key_open)
        |=> (!stall && ctrl_q[13]));

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && bus_we) |=> (ctrl_q[14:0] == $past(ctrl_q[14:0])));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[13] && !(bus_we && bus_sel == 3'd0 && !stall)) |=> ctrl_q[13]);

endmodule

bind flash_row_ctrl flash_row_ctrl_chk #(
    .OP_CYCLES(OP_CYCLES), .FA_W(FA_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .stall(stall), .fl_we(fl_we),
    .fl_addr(fl_addr), .key_open(key_open)
);

// File: tb/flash_row_ctrl_test.sv
`timescale 1ns/1ps
module flash_row_ctrl_test;

    localparam int WORD_W = 24;
    localparam int OPC    = 48;
    localparam int IDX_W  = 5;
    localparam int FA_W   = 23;
    localparam logic [23:0] ONES = 24'hFFFFFF;

    // {setup ctrl, key1, key2, start ctrl, expect run, expect err}
    localparam int NV = 7;
    localparam logic [49:0] VEC [NV] = '{
        {16'h4041, 8'h55, 8'hAA, 16'hC041, 1'b1, 1'b0},
        {16'h4041, 8'hAA, 8'h55, 16'hC041, 1'b0, 1'b1},
        {16'h4041, 8'h55, 8'h55, 16'hC041, 1'b0, 1'b1},
        {16'h0041, 8'h55, 8'hAA, 16'hC041, 1'b0, 1'b1},
        {16'h4041, 8'h55, 8'hAA, 16'hC042, 1'b0, 1'b1},
        {16'h4001, 8'h00, 8'hAA, 16'hC001, 1'b0, 1'b1},
        {16'h4001, 8'h55, 8'hAA, 16'hC001, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [2:0]        bus_sel = '0;
    logic [IDX_W-1:0]  bus_idx = '0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [15:0]       ctrl_q;
    logic              stall, fl_we;
    logic [FA_W-1:0]   fl_addr;
    logic [WORD_W-1:0] fl_wdata;

    int n_chk = 0, n_bad = 0;
    int wr_count = 0, bad_addr = 0, bad_order = 0;
    int idx_exp = 0;
    logic [15:0] exp_hi = '0;
    logic [23:0] mem [128];

    always #2 clk = ~clk;

    flash_row_ctrl #(.OP_CYCLES(OPC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .stall(stall),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata)
    );

    // behavioural array, sampled away from the active edge
    always @(negedge clk) begin
        if (fl_we) begin
            mem[fl_addr[6:0]] <= fl_wdata;
            wr_count <= wr_count + 1;
            if (fl_addr[22:7] != exp_hi) bad_addr <= bad_addr + 1;
            if (int'(fl_addr[4:0]) != idx_exp) bad_order <= bad_order + 1;
            idx_exp <= idx_exp + 1;
        end else if (!stall) begin
            idx_exp <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [IDX_W-1:0] idx, input logic [23:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (stall === 1'b1) @(negedge clk);
    endtask

    task automatic run_op(input logic [15:0] setup, input logic [15:0] go);
        wr(3'd0, 0, {8'h0, setup});
        wr(3'd3, 0, 24'h55);
        wr(3'd3, 0, 24'hAA);
        wr(3'd0, 0, {8'h0, go});
        wait_idle();
    endtask

    function automatic logic [23:0] pat(input int i);
        return 24'(i * 32'h00010203) ^ 24'hA55A00;
    endfunction

    function automatic int row_diff(input int row, input bit use_pat, input logic [23:0] v);
        int d = 0;
        for (int i = 0; i < 32; i++) begin
            if (mem[row*32+i] !== (use_pat ? pat(i) : v)) d++;
        end
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, w0;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctrl_q === 16'h0, "R1 ctrl", ctrl_q, 0);
        chk(stall === 1'b0 && fl_we === 1'b0, "R1 stall/we", {stall, fl_we}, 0);

        // R1 latches reset to ones: program row 2 with no latch writes
        wr(3'd2, 0, 24'h0080);
        run_op(16'h4001, 16'hC001);
        chk(row_diff(2, 0, ONES) == 0, "R1 latch reset", row_diff(2, 0, ONES), 0);

        // R8 program row 1 with pattern, R6 stall length
        wr(3'd2, 0, 24'h0040);
        for (int i = 0; i < 32; i++) wr(3'd4, IDX_W'(i), pat(i));
        wr(3'd0, 0, 24'h4001);
        wr(3'd3, 0, 24'h55);
        wr(3'd3, 0, 24'hAA);
        wr(3'd0, 0, 24'hC001);
        chk(ctrl_q[15] === 1'b1, "R6 busy bit", ctrl_q, 16'h8000);
        n = 0;
        while (stall === 1'b1) begin n++; @(negedge clk); end
        chk(n == OPC, "R6 stall length", n, OPC);
        chk(ctrl_q[15] === 1'b0, "R6 busy cleared", ctrl_q, 0);
        chk(row_diff(1, 1, 0) == 0, "R8 program data", row_diff(1, 1, 0), 0);

        // R8 latches cleared after program
        wr(3'd2, 0, 24'h00C0);
        run_op(16'h4001, 16'hC001);
        chk(row_diff(3, 0, ONES) == 0, "R8 latch clear", row_diff(3, 0, ONES), 0);

        // R7 erase row 1
        wr(3'd2, 0, 24'h0040);
        run_op(16'h4041, 16'hC041);
        chk(row_diff(1, 0, ONES) == 0, "R7 erase", row_diff(1, 0, ONES), 0);

        // R2 R4 key order and start conditions, table walk on row 3
        wr(3'd2, 0, 24'h00C0);
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, 0, {8'h0, VEC[v][49:34]});
            wr(3'd3, 0, {16'h0, VEC[v][33:26]});
            wr(3'd3, 0, {16'h0, VEC[v][25:18]});
            w0 = wr_count;
            wr(3'd0, 0, {8'h0, VEC[v][17:2]});
            chk(stall === VEC[v][1], $sformatf("R2 R4 vec %0d run", v), stall, VEC[v][1]);
            wait_idle();
            @(negedge clk);
            chk(ctrl_q[13] === VEC[v][0], $sformatf("R4 vec %0d err", v), ctrl_q[13], VEC[v][0]);
            chk(wr_count - w0 == (VEC[v][1] ? 32 : 0), $sformatf("R4 vec %0d writes", v),
                wr_count - w0, VEC[v][1] ? 32 : 0);
        end

        // R3 unlock consumed by a control write that does not start
        wr(3'd0, 0, 24'h4001);
        wr(3'd3, 0, 24'h55);
        wr(3'd3, 0, 24'hAA);
        wr(3'd0, 0, 24'h4001);
        w0 = wr_count;
        wr(3'd0, 0, 24'hC001);
        chk(stall === 1'b0 && ctrl_q[13] === 1'b1, "R3 unlock consumed", ctrl_q, 16'h6001);
        repeat (2) @(negedge clk);
        chk(wr_count == w0, "R3 no writes", wr_count - w0, 0);

        // R5 error sticky
        wr(3'd3, 0, 24'h55);
        wr(3'd1, 0, 24'h00);
        wr(3'd4, 0, 24'h123456);
        chk(ctrl_q[13] === 1'b1, "R5 sticky other regs", ctrl_q, 16'h6001);
        wr(3'd0, 0, 24'h6001);
        chk(ctrl_q[13] === 1'b1, "R5 sticky write 1", ctrl_q, 16'h6001);
        wr(3'd0, 0, 24'h4001);
        chk(ctrl_q === 16'h4001, "R5 clear", ctrl_q, 16'h4001);

        // R9 writes ignored while busy (latch 0 now holds 123456)
        wr(3'd2, 0, 24'h0000);
        wr(3'd3, 0, 24'h55);
        wr(3'd3, 0, 24'hAA);
        wr(3'd0, 0, 24'hC001);
        wr(3'd4, 1, 24'h0BADBA);
        wr(3'd0, 0, 24'h0000);
        wr(3'd2, 0, 24'h0100);
        wr(3'd3, 0, 24'h55);
        wait_idle();
        @(negedge clk);
        chk(ctrl_q === 16'h4001, "R9 ctrl kept", ctrl_q, 16'h4001);
        chk(mem[0] === 24'h123456, "R9 word0", mem[0], 24'h123456);
        chk(mem[1] === ONES, "R9 latch ignored", mem[1], ONES);
        run_op(16'h4041, 16'hC041);
        chk(row_diff(0, 0, ONES) == 0, "R9 offset kept", row_diff(0, 0, ONES), 0);

        // R7 row address with a nonzero page
        exp_hi = 16'h1200;
        wr(3'd1, 0, 24'h12);
        wr(3'd2, 0, 24'h0080);
        w0 = wr_count;
        run_op(16'h4041, 16'hC041);
        chk(wr_count - w0 == 32, "R7 page op writes", wr_count - w0, 32);

        repeat (2) @(negedge clk);
        chk(bad_addr == 0, "R7 row address", bad_addr, 0);
        chk(bad_order == 0, "R10 word order", bad_order, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule